// File: doc/BRIEF.md
# Fractional Auto-Advance Stream Bank

This block holds a set of independent read cursors into a byte-wide synchronous RAM. Each cursor has a fixed-point position and its own fixed-point step. A read names a cursor, returns the RAM byte at the whole-number part of that cursor's position, and then moves the cursor on by its step. With a step of one the cursor walks consecutive bytes. A step below one repeats each byte for several reads. A step of two skips every second byte. A step of zero holds the cursor on one byte.

There are 32 general cursors, numbered 0 to 31, and one message cursor, number 32. A configuration port loads positions and steps for any cursor. The message cursor also has its own side path. That path can load its position and store bytes at that position, moving the cursor forward by one after each store. The block is the only master of the RAM. Reads take the RAM before message stores.

Top module: `frac_stream_bank`

## Requirements
- R1: After reset every cursor position is 0.0, every step is 1.0 (0x0100), and `rd_valid` is low.
- R2: A read request with `rd_idx` at most 32 drives `ram_en` high, `ram_we` low and `ram_addr` equal to the cursor's whole part in that same cycle. `rd_valid` is high for exactly one cycle, two clock edges after the request, with the RAM byte on `rd_data`.
- R3: After a read, the cursor's 16.16 position grows by its 8.8 step, with the binary points aligned, and wraps modulo 2^32.
- R4: A step with a fraction, such as 0x0040 (0.25) or 0x0200 (2.0), makes the whole part repeat bytes or skip them to match the accumulated value.
- R5: A step of zero leaves the position unchanged on every read, so each read returns the same byte.
- R6: A configuration write uses `cfg_sel`. 0 loads the whole part and clears the fraction. 1 loads the fraction and keeps the whole part. 2 loads the step. 3 does nothing. A write with `cfg_idx` above 32 does nothing.
- R7: A configuration write (select 0 to 2) and a read to the same cursor in the same cycle: the write takes effect. The read still returns the byte at the old position, and its advance is dropped.
- R8: A message store (`msg_we`) with no read in the same cycle writes `msg_wdata` to RAM at the message cursor's whole part. The cursor then grows by 1.0.
- R9: `msg_ptr_load` sets the message cursor's whole part to `msg_ptr_addr` and clears its fraction. A configuration write to cursor 32 in the same cycle wins over it.
- R10: A message store issued in the same cycle as a valid read is discarded. RAM and the message cursor are left unchanged.
- R11: A read with `rd_idx` above 32 makes no RAM access, produces no `rd_valid`, and changes no cursor.
- R12: Cursors are independent. A read or a write to one cursor leaves every other cursor unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration target: 0 whole part, 1 fraction, 2 step, 3 none |
| cfg_idx | input | 6 | Cursor number for configuration |
| cfg_data | input | 16 | Configuration value |
| rd_req | input | 1 | Stream read request |
| rd_idx | input | 6 | Cursor number to read |
| rd_valid | output | 1 | One-cycle flag for returned data |
| rd_data | output | 8 | Returned byte |
| msg_we | input | 1 | Message store strobe |
| msg_wdata | input | 8 | Message byte to store |
| msg_ptr_load | input | 1 | Message cursor load strobe |
| msg_ptr_addr | input | 16 | Message cursor whole part to load |
| ram_en | output | 1 | RAM access enable |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | 16 | RAM byte address |
| ram_wdata | output | 8 | RAM write data |
| ram_rdata | input | 8 | RAM read data, valid one edge after a read access |

## Verification
Steps of 1.0, 0.25, 2.0 and 0 are run over RAM bytes that all differ. A wrong alignment of the step against the position therefore shows up as wrong bytes, not just as wrong timing. Starting fractions that are not zero tell apart the wrap from fraction into whole part and a cursor that only counts whole steps. Interleaved reads across cursors expose cross-talk between cursors. Same-cycle collisions cover several cases: configuration against read, load against configuration, and store against read. Out-of-range indices and the unused select code show whether priority and ignore rules are honoured at the RAM pins and in later returned bytes.

// File: rtl/frac_stream_pkg.sv
package frac_stream_pkg;

  localparam int GP_CURSORS_DEF = 32;
  localparam int ADDR_W_DEF     = 16;
  localparam int FRAC_W_DEF     = 16;
  localparam int STEP_I_W_DEF   = 8;
  localparam int STEP_F_W_DEF   = 8;
  localparam int DATA_W_DEF     = 8;

  typedef enum logic [1:0] {
    CFG_POS_WHOLE = 2'd0,
    CFG_POS_FRAC  = 2'd1,
    CFG_STEP      = 2'd2,
    CFG_NOP       = 2'd3
  } cfg_sel_e;

endpackage

// File: rtl/fstrm_cursor.sv
module fstrm_cursor
  import frac_stream_pkg::*;
#(
  parameter int ADDR_W = ADDR_W_DEF,
  parameter int FRAC_W = FRAC_W_DEF,
  parameter int STEP_W = STEP_I_W_DEF + STEP_F_W_DEF,
  parameter int STEP_F_W = STEP_F_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_hit_i,
  input  logic [1:0]        cfg_sel_i,
  input  logic [ADDR_W-1:0] cfg_data_i,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_val_i,
  input  logic              adv_i,
  input  logic              bump_i,
  output logic [ADDR_W-1:0] addr_o
);

  localparam int POS_W = ADDR_W + FRAC_W;
  localparam int SHIFT = FRAC_W - STEP_F_W;
  localparam logic [STEP_W-1:0] STEP_ONE = STEP_W'(1) << STEP_F_W;
  localparam logic [POS_W-1:0]  POS_ONE  = POS_W'(1) << FRAC_W;

  logic [POS_W-1:0]  pos_q, pos_d;
  logic [STEP_W-1:0] step_q, step_d;
  logic              pos_en, step_en;
  logic [POS_W-1:0]  step_al;

  assign step_al = POS_W'(step_q) << SHIFT;

  always_comb begin
    pos_d   = pos_q;
    step_d  = step_q;
    pos_en  = 1'b0;
    step_en = 1'b0;
    if (host_hit_i) begin
      unique case (cfg_sel_i)
        CFG_POS_WHOLE: begin
          pos_d  = {cfg_data_i, {FRAC_W{1'b0}}};
          pos_en = 1'b1;
        end
        CFG_POS_FRAC: begin
          pos_d  = {pos_q[POS_W-1:FRAC_W], cfg_data_i[FRAC_W-1:0]};
          pos_en = 1'b1;
        end
        CFG_STEP: begin
          step_d  = cfg_data_i[STEP_W-1:0];
          step_en = 1'b1;
        end
        default: ;
      endcase
    end else if (load_i) begin
      pos_d  = {load_val_i, {FRAC_W{1'b0}}};
      pos_en = 1'b1;
    end else if (bump_i) begin
      pos_d  = pos_q + POS_ONE;
      pos_en = 1'b1;
    end else if (adv_i) begin
      pos_d  = pos_q + step_al;
      pos_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q  <= '0;
      step_q <= STEP_ONE;
    end else begin
      if (pos_en)  pos_q  <= pos_d;
      if (step_en) step_q <= step_d;
    end
  end

  assign addr_o = pos_q[POS_W-1:FRAC_W];

  // R5: zero step keeps the cursor where it is
  a_r5_zero_step_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && !host_hit_i && !load_i && !bump_i && step_q == '0) |=> $stable(pos_q));

  // R6: loading the whole part leaves no fraction behind
  a_r6_whole_clears_frac: assert property (@(posedge clk) disable iff (!rst_n)
    (host_hit_i && cfg_sel_i == CFG_POS_WHOLE) |=> (pos_q[FRAC_W-1:0] == '0));

  // R12: an untouched cursor does not move
  a_r12_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!host_hit_i && !load_i && !adv_i && !bump_i) |=> ($stable(pos_q) && $stable(step_q)));

endmodule

// File: rtl/fstrm_rdpipe.sv
module fstrm_rdpipe
  import frac_stream_pkg::*;
#(
  parameter int DATA_W = DATA_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue_i,
  input  logic [DATA_W-1:0] ram_rdata_i,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_data_o
);

  logic              issue_q;
  logic              valid_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      issue_q <= 1'b0;
      valid_q <= 1'b0;
      data_q  <= '0;
    end else begin
      issue_q <= issue_i;
      valid_q <= issue_q;
      if (issue_q) data_q <= ram_rdata_i;
    end
  end

  assign rd_valid_o = valid_q;
  assign rd_data_o  = data_q;

  // R2: every accepted read yields a strobe two edges later
  a_r2_valid_two_later: assert property (@(posedge clk) disable iff (!rst_n)
    issue_i |=> ##1 rd_valid_o);

endmodule

// File: rtl/frac_stream_bank.sv
module frac_stream_bank
  import frac_stream_pkg::*;
#(
  parameter int GP_CURSORS = GP_CURSORS_DEF,
  parameter int ADDR_W     = ADDR_W_DEF,
  parameter int FRAC_W     = FRAC_W_DEF,
  parameter int STEP_I_W   = STEP_I_W_DEF,
  parameter int STEP_F_W   = STEP_F_W_DEF,
  parameter int DATA_W     = DATA_W_DEF,
  localparam int NUM       = GP_CURSORS + 1,
  localparam int MSG_IDX   = GP_CURSORS,
  localparam int IDX_W     = $clog2(NUM),
  localparam int STEP_W    = STEP_I_W + STEP_F_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [ADDR_W-1:0] cfg_data,
  input  logic              rd_req,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  input  logic              msg_we,
  input  logic [DATA_W-1:0] msg_wdata,
  input  logic              msg_ptr_load,
  input  logic [ADDR_W-1:0] msg_ptr_addr,
  output logic              ram_en,
  output logic              ram_we,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [DATA_W-1:0] ram_wdata,
  input  logic [DATA_W-1:0] ram_rdata
);

  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic              rd_fire;
  logic              msg_fire;
  logic              cfg_live;
  logic [ADDR_W-1:0] addr_all [NUM];
  logic [ADDR_W-1:0] rd_addr;

  assign rd_fire  = rd_req && (rd_idx < IDX_W'(NUM));
  assign msg_fire = msg_we && !rd_fire;
  assign cfg_live = cfg_we && (cfg_sel != CFG_NOP);

  for (genvar s = 0; s < NUM; s++) begin : g_cursor
    logic hit, adv, load, bump;
    assign hit = cfg_live && (cfg_idx == IDX_W'(s));
    assign adv = rd_fire && (rd_idx == IDX_W'(s));
    if (s == MSG_IDX) begin : g_msg
      assign load = msg_ptr_load;
      assign bump = msg_fire;
    end else begin : g_gp
      assign load = 1'b0;
      assign bump = 1'b0;
    end
    fstrm_cursor #(
      .ADDR_W  (ADDR_W),
      .FRAC_W  (FRAC_W),
      .STEP_W  (STEP_W),
      .STEP_F_W(STEP_F_W)
    ) u_cursor (
      .clk       (clk),
      .rst_n     (rst_int_n),
      .host_hit_i(hit),
      .cfg_sel_i (cfg_sel),
      .cfg_data_i(cfg_data),
      .load_i    (load),
      .load_val_i(msg_ptr_addr),
      .adv_i     (adv),
      .bump_i    (bump),
      .addr_o    (addr_all[s])
    );
  end

  always_comb begin
    rd_addr = '0;
    for (int s = 0; s < NUM; s++) begin
      if (rd_idx == IDX_W'(s)) rd_addr = addr_all[s];
    end
  end

  assign ram_en    = rd_fire || msg_fire;
  assign ram_we    = msg_fire;
  assign ram_addr  = rd_fire ? rd_addr : addr_all[MSG_IDX];
  assign ram_wdata = msg_wdata;

  fstrm_rdpipe #(.DATA_W(DATA_W)) u_rdpipe (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .issue_i    (rd_fire),
    .ram_rdata_i(ram_rdata),
    .rd_valid_o (rd_valid),
    .rd_data_o  (rd_data)
  );

  // R11: a read of a missing cursor leaves the RAM idle
  a_r11_bad_idx_quiet: assert property (@(posedge clk) disable iff (!rst_int_n)
    (rd_req && rd_idx >= IDX_W'(NUM) && !msg_we) |-> !ram_en);

  // R10: a read in the same cycle keeps the RAM from being written
  a_r10_read_blocks_store: assert property (@(posedge clk) disable iff (!rst_int_n)
    (rd_req && rd_idx < IDX_W'(NUM)) |-> !ram_we);

endmodule

// File: tb/frac_stream_bank_tb_top.sv
`timescale 1ns/1ps
module frac_stream_bank_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [1:0]  cfg_sel;
  logic [5:0]  cfg_idx;
  logic [15:0] cfg_data;
  logic        rd_req;
  logic [5:0]  rd_idx;
  logic        rd_valid;
  logic [7:0]  rd_data;
  logic        msg_we;
  logic [7:0]  msg_wdata;
  logic        msg_ptr_load;
  logic [15:0] msg_ptr_addr;
  logic        ram_en, ram_we;
  logic [15:0] ram_addr;
  logic [7:0]  ram_wdata;
  logic [7:0]  ram_rdata;

  always #2.5 clk = ~clk;

  frac_stream_bank dut_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_idx(cfg_idx), .cfg_data(cfg_data),
    .rd_req(rd_req), .rd_idx(rd_idx), .rd_valid(rd_valid), .rd_data(rd_data),
    .msg_we(msg_we), .msg_wdata(msg_wdata),
    .msg_ptr_load(msg_ptr_load), .msg_ptr_addr(msg_ptr_addr),
    .ram_en(ram_en), .ram_we(ram_we), .ram_addr(ram_addr),
    .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
  );

  // Environment RAM: 256 bytes, synchronous read
  logic [7:0] mem [256];
  always @(posedge clk) begin
    if (ram_en) begin
      if (ram_we) mem[ram_addr[7:0]] <= ram_wdata;
      else        ram_rdata <= mem[ram_addr[7:0]];
    end
  end

  // Reference model state
  bit [31:0] m_pos  [33];
  bit [15:0] m_step [33];
  bit [7:0]  m_mem  [256];
  bit        s1_v;
  bit [7:0]  s1_d;
  int        vectors = 0;
  int        miscmp  = 0;
  bit        done    = 0;

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscmp++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic cyc(input string tag);
    bit        fire, mfire, e_en, hh, n_v;
    bit [15:0] e_addr;
    bit [7:0]  n_d;
    fire   = rd_req && (rd_idx < 33);
    mfire  = msg_we && !fire;
    e_en   = fire || mfire;
    e_addr = fire ? m_pos[rd_idx][31:16] : m_pos[32][31:16];
    #1;
    chk(tag, "ram_en", 32'(ram_en), 32'(e_en));
    chk(tag, "ram_we", 32'(ram_we), 32'(mfire));
    if (e_en) chk(tag, "ram_addr", 32'(ram_addr), 32'(e_addr));
    if (mfire) chk(tag, "ram_wdata", 32'(ram_wdata), 32'(msg_wdata));
    n_v = fire;
    n_d = m_mem[e_addr[7:0]];
    for (int s = 0; s < 33; s++) begin
      hh = cfg_we && (cfg_sel != 2'd3) && (cfg_idx == 6'(s));
      if (hh) begin
        case (cfg_sel)
          2'd0: m_pos[s] = {cfg_data, 16'h0000};
          2'd1: m_pos[s][15:0] = cfg_data;
          default: m_step[s] = cfg_data;
        endcase
      end else if (s == 32 && msg_ptr_load) m_pos[s] = {msg_ptr_addr, 16'h0000};
      else if (s == 32 && mfire) m_pos[s] = m_pos[s] + 32'h0001_0000;
      else if (fire && rd_idx == 6'(s)) m_pos[s] = m_pos[s] + {8'h00, m_step[s], 8'h00};
    end
    if (mfire) m_mem[e_addr[7:0]] = msg_wdata;
    @(posedge clk);
    @(negedge clk);
    chk(tag, "rd_valid", 32'(rd_valid), 32'(s1_v));
    if (s1_v) chk(tag, "rd_data", 32'(rd_data), 32'(s1_d));
    s1_v = n_v;
    s1_d = n_d;
  endtask

  task automatic clr();
    cfg_we = 0; cfg_sel = 0; cfg_idx = 0; cfg_data = 0;
    rd_req = 0; rd_idx = 0; msg_we = 0; msg_wdata = 0;
    msg_ptr_load = 0; msg_ptr_addr = 0;
  endtask

  task automatic idle(input string tag, input int n);
    for (int i = 0; i < n; i++) cyc(tag);
  endtask

  task automatic cfg(input string tag, input int idx, input int sel, input int data);
    cfg_we = 1; cfg_idx = 6'(idx); cfg_sel = 2'(sel); cfg_data = 16'(data);
    cyc(tag); clr();
  endtask

  task automatic rd(input string tag, input int idx, input int n);
    for (int i = 0; i < n; i++) begin
      rd_req = 1; rd_idx = 6'(idx);
      cyc(tag); clr();
    end
  endtask

  task automatic mstore(input string tag, input int data);
    msg_we = 1; msg_wdata = 8'(data);
    cyc(tag); clr();
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem[i]   = 8'(i * 37 + 11);
      m_mem[i] = 8'(i * 37 + 11);
    end
    for (int s = 0; s < 33; s++) begin
      m_pos[s]  = 0;
      m_step[s] = 16'h0100;
    end
    s1_v = 0; s1_d = 0;
    clr();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    idle("R1", 4);
    // R1: reset position 0.0 and step 1.0
    rd("R1", 5, 2);
    idle("R1", 2);
    // R2 R3: unit step walk
    cfg("R3", 3, 0, 16'h0010);
    rd("R2", 3, 4);
    idle("R2", 2);
    // R4: quarter step with a fractional start, then double step
    cfg("R4", 4, 0, 16'h0020);
    cfg("R4", 4, 1, 16'h8000);
    cfg("R4", 4, 2, 16'h0040);
    rd("R4", 4, 7);
    cfg("R4", 6, 0, 16'h0040);
    cfg("R4", 6, 2, 16'h0200);
    rd("R4", 6, 4);
    // R3: wrap modulo 2^32
    cfg("R3", 2, 0, 16'hFFFF);
    cfg("R3", 2, 1, 16'hC000);
    cfg("R3", 2, 2, 16'h0180);
    rd("R3", 2, 3);
    // R5: zero step
    cfg("R5", 7, 0, 16'h0033);
    cfg("R5", 7, 2, 16'h0000);
    rd("R5", 7, 4);
    // R6: select encodings and ignored writes
    cfg("R6", 8, 0, 16'h0030);
    cfg("R6", 8, 1, 16'hC000);
    cfg("R6", 8, 2, 16'h0040);
    rd("R6", 8, 2);
    cfg("R6", 8, 3, 16'h0090);
    cfg("R6", 40, 0, 16'h0077);
    rd("R6", 8, 3);
    cfg("R6", 8, 0, 16'h0035);
    rd("R6", 8, 2);
    // R7: configuration wins over a read of the same cursor
    cfg("R7", 9, 0, 16'h0050);
    cfg_we = 1; cfg_idx = 9; cfg_sel = 0; cfg_data = 16'h0060;
    rd_req = 1; rd_idx = 9;
    cyc("R7"); clr();
    rd("R7", 9, 2);
    // R8 R9: message path stores then reads back
    msg_ptr_load = 1; msg_ptr_addr = 16'h0080;
    cyc("R9"); clr();
    mstore("R8", 8'hA5);
    mstore("R8", 8'h5A);
    cfg("R9", 32, 0, 16'h0080);
    rd("R8", 32, 3);
    // R9: configuration beats message load
    msg_ptr_load = 1; msg_ptr_addr = 16'h00C0;
    cfg_we = 1; cfg_idx = 32; cfg_sel = 0; cfg_data = 16'h00A0;
    cyc("R9"); clr();
    mstore("R9", 8'h3C);
    cfg("R9", 32, 0, 16'h00A0);
    rd("R9", 32, 2);
    // R10: store colliding with a read is dropped
    msg_ptr_load = 1; msg_ptr_addr = 16'h00B0;
    cyc("R10"); clr();
    msg_we = 1; msg_wdata = 8'hEE; rd_req = 1; rd_idx = 3;
    cyc("R10"); clr();
    mstore("R10", 8'h77);
    cfg("R10", 32, 0, 16'h00B0);
    rd("R10", 32, 2);
    // R11: reads of a missing cursor
    rd("R11", 45, 2);
    rd("R11", 33, 1);
    rd("R11", 3, 1);
    // R12: interleaved cursors
    for (int i = 0; i < 4; i++) begin
      rd("R12", 3, 1);
      rd("R12", 4, 1);
      rd("R12", 6, 1);
    end
    idle("R12", 3);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      miscmp++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
      $finish;
    end
  end

endmodule